// File: doc/BRIEF.md
# Paired-Page Address Translation Buffer

This block is a fully associative translation buffer for 32-bit virtual addresses. Every entry describes two neighbouring pages, an even one and an odd one, that share one virtual tag. The page size is set per entry by a page mask on top of a 4 KiB minimum. The two halves have separate physical frame bases, valid bits and dirty bits. An entry is visible to all address spaces when its global flag is set. Otherwise it is visible only to the 8-bit address-space identifier stored with it.

A lookup is offered on a valid/ready request channel. The request carries a virtual address, a write flag and the current address-space identifier. The result comes back one cycle later on a response channel that waits for the consumer. The result carries a 2-bit code (translated, no entry, half invalid, clean page written), the physical address, and read and write permission. Entries are loaded through a single write port, one whole entry per cycle.

Top module: `tlb_pair_lookup`

## Requirements
- R1: After reset `rsp_valid` is 0 and `req_ready` is 1, and any lookup made before an entry is loaded returns code 1 (no entry).
- R2: An entry takes part in a lookup only when its global flag is set or its stored identifier equals `req_asid`.
- R3: The per-entry compare mask is the entry's page mask ORed with bits 12..0. An entry matches when the request address and the stored tag agree on every bit outside that mask. This allows pairs of 4 KiB, 16 KiB and larger pages.
- R4: The half is chosen by the highest bit of the compare mask: the bit that is set in the mask but clear in the mask shifted right by one. 0 selects the even half and 1 selects the odd half.
- R5: A match whose selected half has its valid bit clear returns code 2 (invalid), with physical address 0 and no read or write permission.
- R6: A read match, or a write match on a dirty half, returns code 0 (translated). The physical address is that half's frame base ORed with the request address bits under the compare mask shifted right by one. Read permission is 1 and write permission equals the half's dirty bit.
- R7: A write match on a valid half whose dirty bit is clear returns code 3 (modified), with physical address 0 and no permission.
- R8: When several entries match, the entry with the lowest index decides the result.
- R9: When no entry matches, the result is code 1 (no entry) with physical address 0. An entry whose two valid bits are both clear never matches.
- R10: An entry write is seen by lookups starting in the next cycle. A lookup accepted in the same cycle as the write sees the old contents.
- R11: `req_ready` equals `!rsp_valid || rsp_ready`. An accepted request is answered in the following cycle. A response held back by `rsp_ready` low stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Lookup request can be taken |
| req_va | input | 32 | Virtual address to translate |
| req_write | input | 1 | 1 for a store access, 0 for a load |
| req_asid | input | 8 | Current address-space identifier |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_code | output | 2 | 0 translated, 1 no entry, 2 invalid, 3 modified |
| rsp_pa | output | 32 | Physical address (0 unless code 0) |
| rsp_rd | output | 1 | Read permission |
| rsp_wr | output | 1 | Write permission |
| wr_en | input | 1 | Load an entry this cycle |
| wr_idx | input | 4 | Index of the entry to load |
| wr_global | input | 1 | Entry ignores the identifier |
| wr_asid | input | 8 | Identifier stored with the entry |
| wr_vpn | input | 32 | Virtual tag (address of the even page) |
| wr_pmask | input | 32 | Page mask bits added above bit 12 |
| wr_pfn0 | input | 32 | Physical base of the even half |
| wr_v0 | input | 1 | Even half valid |
| wr_d0 | input | 1 | Even half dirty (writable) |
| wr_pfn1 | input | 32 | Physical base of the odd half |
| wr_v1 | input | 1 | Odd half valid |
| wr_d1 | input | 1 | Odd half dirty (writable) |

## Verification
The bench uses the default configuration: 16 entries, a 4 KiB minimum page and an 8-bit identifier. This lets it place overlapping entries at indices 0, 2 and 3 to test lowest-index priority, and use the last index, 15. It loads one entry with a 16 KiB page mask next to 4 KiB entries, so half selection is tested on two different bits (12 and 14). The entries that are never loaded stay in place and act as zero-tag entries that must stay silent.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

    localparam int VA_W        = 32;
    localparam int PA_W        = 32;
    localparam int ASID_W      = 8;
    localparam int MIN_PG_BITS = 12;
    localparam int N_ENT       = 16;

    typedef enum logic [1:0] {
        CODE_MATCH    = 2'd0,
        CODE_NOMATCH  = 2'd1,
        CODE_INVALID  = 2'd2,
        CODE_MODIFIED = 2'd3
    } tlb_code_e;

    typedef struct packed {
        logic              global_en;
        logic [ASID_W-1:0] asid;
        logic [VA_W-1:0]   vpn;
        logic [VA_W-1:0]   pmask;
        logic [PA_W-1:0]   pfn0;
        logic [PA_W-1:0]   pfn1;
        logic              v0;
        logic              d0;
        logic              v1;
        logic              d1;
    } tlb_entry_t;

    typedef struct packed {
        logic            valid;
        tlb_code_e       code;
        logic [PA_W-1:0] pa;
        logic            rd;
        logic            wr;
    } tlb_rsp_t;

endpackage

// File: rtl/tlb_entry_store.sv
module tlb_entry_store
    import tlb_pkg::*;
#(
    parameter int N = N_ENT,
    localparam int IW = $clog2(N)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [IW-1:0] wr_idx,
    input  tlb_entry_t wr_entry,
    output tlb_entry_t ents [N]
);

    tlb_entry_t tbl_d [N];
    tlb_entry_t tbl_q [N];

    always_comb begin
        for (int i = 0; i < N; i++) begin
            tbl_d[i] = tbl_q[i];
            if (wr_en && (IW'(i) == wr_idx)) begin
                tbl_d[i] = wr_entry;
            end
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < N; i++) begin
            if (!rst_n) begin
                tbl_q[i] <= '0;
            end else begin
                tbl_q[i] <= tbl_d[i];
            end
        end
    end

    always_comb begin
        for (int i = 0; i < N; i++) begin
            ents[i] = tbl_q[i];
        end
    end

endmodule

// File: rtl/tlb_lane.sv
module tlb_lane
    import tlb_pkg::*;
(
    input  tlb_entry_t        ent,
    input  logic [VA_W-1:0]   va,
    input  logic [ASID_W-1:0] asid,
    input  logic              is_write,
    output logic              hit,
    output tlb_code_e         code,
    output logic [PA_W-1:0]   pa,
    output logic              wperm
);

    localparam logic [VA_W-1:0] LOW_SPAN = VA_W'((64'd1 << (MIN_PG_BITS + 1)) - 64'd1);

    logic [VA_W-1:0] eff_mask;
    logic [VA_W-1:0] half_mask;
    logic            owner_ok;
    logic            tag_eq;
    logic            odd;
    logic            half_v;
    logic            half_d;

    always_comb begin
        eff_mask  = ent.pmask | LOW_SPAN;
        half_mask = eff_mask >> 1;
        owner_ok  = ent.global_en || (ent.asid == asid);
        tag_eq    = (va & ~eff_mask) == (ent.vpn & ~eff_mask);
        hit       = (ent.v0 || ent.v1) && owner_ok && tag_eq;
        odd       = |(va & eff_mask & ~half_mask);
        half_v    = odd ? ent.v1 : ent.v0;
        half_d    = odd ? ent.d1 : ent.d0;

        code  = CODE_MATCH;
        pa    = '0;
        wperm = 1'b0;
        if (!half_v) begin
            code = CODE_INVALID;
        end else if (is_write && !half_d) begin
            code = CODE_MODIFIED;
        end else begin
            pa    = (odd ? ent.pfn1 : ent.pfn0) | PA_W'(va & half_mask);
            wperm = half_d;
        end
    end

endmodule

// File: rtl/tlb_pick.sv
module tlb_pick
    import tlb_pkg::*;
#(
    parameter int N = N_ENT,
    localparam int IW = $clog2(N)
) (
    input  logic [N-1:0]    hit_vec,
    input  tlb_code_e       lane_code [N],
    input  logic [PA_W-1:0] lane_pa [N],
    input  logic [N-1:0]    lane_wperm,
    output tlb_code_e       code,
    output logic [PA_W-1:0] pa,
    output logic            rd,
    output logic            wr
);

    logic [IW-1:0] sel;
    logic          any;

    always_comb begin
        sel = '0;
        any = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (hit_vec[i]) begin
                sel = IW'(i);
                any = 1'b1;
            end
        end

        if (any) begin
            code = lane_code[sel];
            pa   = lane_pa[sel];
            wr   = lane_wperm[sel];
        end else begin
            code = CODE_NOMATCH;
            pa   = '0;
            wr   = 1'b0;
        end
        rd = (code == CODE_MATCH);
    end

endmodule

// File: rtl/tlb_pair_lookup.sv
module tlb_pair_lookup
    import tlb_pkg::*;
#(
    parameter int N = N_ENT,
    localparam int IW = $clog2(N)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [VA_W-1:0]   req_va,
    input  logic              req_write,
    input  logic [ASID_W-1:0] req_asid,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [1:0]        rsp_code,
    output logic [PA_W-1:0]   rsp_pa,
    output logic              rsp_rd,
    output logic              rsp_wr,
    input  logic              wr_en,
    input  logic [IW-1:0]     wr_idx,
    input  logic              wr_global,
    input  logic [ASID_W-1:0] wr_asid,
    input  logic [VA_W-1:0]   wr_vpn,
    input  logic [VA_W-1:0]   wr_pmask,
    input  logic [PA_W-1:0]   wr_pfn0,
    input  logic              wr_v0,
    input  logic              wr_d0,
    input  logic [PA_W-1:0]   wr_pfn1,
    input  logic              wr_v1,
    input  logic              wr_d1
);

    tlb_entry_t      wr_entry;
    tlb_entry_t      ents [N];
    logic [N-1:0]    hit_vec;
    tlb_code_e       lane_code [N];
    logic [PA_W-1:0] lane_pa [N];
    logic [N-1:0]    lane_wperm;
    tlb_code_e       pick_code;
    logic [PA_W-1:0] pick_pa;
    logic            pick_rd;
    logic            pick_wr;
    tlb_rsp_t        rsp_d;
    tlb_rsp_t        rsp_q;

    always_comb begin
        wr_entry = '{global_en: wr_global, asid: wr_asid, vpn: wr_vpn,
                     pmask: wr_pmask, pfn0: wr_pfn0, pfn1: wr_pfn1,
                     v0: wr_v0, d0: wr_d0, v1: wr_v1, d1: wr_d1};
    end

    tlb_entry_store #(.N(N)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_entry (wr_entry),
        .ents     (ents)
    );

    for (genvar g = 0; g < N; g++) begin : g_lane
        tlb_lane u_lane (
            .ent      (ents[g]),
            .va       (req_va),
            .asid     (req_asid),
            .is_write (req_write),
            .hit      (hit_vec[g]),
            .code     (lane_code[g]),
            .pa       (lane_pa[g]),
            .wperm    (lane_wperm[g])
        );
    end

    tlb_pick #(.N(N)) u_pick (
        .hit_vec    (hit_vec),
        .lane_code  (lane_code),
        .lane_pa    (lane_pa),
        .lane_wperm (lane_wperm),
        .code       (pick_code),
        .pa         (pick_pa),
        .rd         (pick_rd),
        .wr         (pick_wr)
    );

    assign req_ready = !rsp_q.valid || rsp_ready;

    always_comb begin
        rsp_d = rsp_q;
        if (req_valid && req_ready) begin
            rsp_d.valid = 1'b1;
            rsp_d.code  = pick_code;
            rsp_d.pa    = pick_pa;
            rsp_d.rd    = pick_rd;
            rsp_d.wr    = pick_wr;
        end else if (rsp_ready) begin
            rsp_d.valid = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_q <= '{valid: 1'b0, code: CODE_NOMATCH, pa: '0, rd: 1'b0, wr: 1'b0};
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign rsp_valid = rsp_q.valid;
    assign rsp_code  = rsp_q.code;
    assign rsp_pa    = rsp_q.pa;
    assign rsp_rd    = rsp_q.rd;
    assign rsp_wr    = rsp_q.wr;

endmodule

// File: rtl/tlb_pair_lookup_chk.sv
module tlb_pair_lookup_chk
    import tlb_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic            req_ready,
    input logic            rsp_valid,
    input logic            rsp_ready,
    input logic [1:0]      rsp_code,
    input logic [PA_W-1:0] rsp_pa,
    input logic            rsp_rd,
    input logic            rsp_wr
);

    assert_ready_rule_R11: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready == (!rsp_valid || rsp_ready));

    assert_one_cycle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> rsp_valid);

    assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_code) && $stable(rsp_pa)
                                       && $stable(rsp_rd) && $stable(rsp_wr)));

    assert_invalid_empty_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_code == 2'd2) |-> (rsp_pa == '0 && !rsp_rd && !rsp_wr));

    assert_modified_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_code == 2'd3) |-> (rsp_pa == '0 && !rsp_rd && !rsp_wr));

    assert_read_perm_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_rd == (rsp_code == 2'd0)));

    assert_nomatch_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_code == 2'd1) |-> (rsp_pa == '0 && !rsp_wr));

endmodule

bind tlb_pair_lookup tlb_pair_lookup_chk u_chk (.*);

// File: tb/sim_tlb_pair_lookup.sv
`timescale 1ns/1ps
module sim_tlb_pair_lookup;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_va = '0;
    logic        req_write = 1'b0;
    logic [7:0]  req_asid = '0;
    logic        rsp_valid;
    logic        rsp_ready = 1'b1;
    logic [1:0]  rsp_code;
    logic [31:0] rsp_pa;
    logic        rsp_rd;
    logic        rsp_wr;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_idx = '0;
    logic        wr_global = 1'b0;
    logic [7:0]  wr_asid = '0;
    logic [31:0] wr_vpn = '0;
    logic [31:0] wr_pmask = '0;
    logic [31:0] wr_pfn0 = '0;
    logic        wr_v0 = 1'b0;
    logic        wr_d0 = 1'b0;
    logic [31:0] wr_pfn1 = '0;
    logic        wr_v1 = 1'b0;
    logic        wr_d1 = 1'b0;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    tlb_pair_lookup u0 (.*);

    typedef struct packed {
        logic [31:0] va;
        logic        wr;
        logic [7:0]  asid;
        logic [1:0]  code;
        logic [31:0] pa;
        logic        wperm;
        logic [3:0]  req;
    } vec_t;

    // codes: 0 translated, 1 no entry, 2 invalid, 3 modified
    localparam vec_t VEC [12] = '{
        '{32'h0040_0123, 1'b0, 8'h11, 2'd0, 32'h1000_0123, 1'b1, 4'd6},  // R6 even half read
        '{32'h0040_1ABC, 1'b1, 8'h11, 2'd3, 32'h0000_0000, 1'b0, 4'd7},  // R7 clean odd written
        '{32'h0040_1ABC, 1'b0, 8'h11, 2'd0, 32'h2000_0ABC, 1'b0, 4'd4},  // R4 odd half, no write perm
        '{32'h0040_0010, 1'b1, 8'h11, 2'd0, 32'h1000_0010, 1'b1, 4'd6},  // R6 dirty write
        '{32'h0040_0010, 1'b0, 8'h22, 2'd0, 32'h4000_0010, 1'b1, 4'd2},  // R2 owner picks entry 2
        '{32'h0040_1004, 1'b0, 8'h33, 2'd0, 32'h5100_0004, 1'b1, 4'd8},  // R8 global entry 3
        '{32'h0080_2345, 1'b0, 8'h99, 2'd2, 32'h0000_0000, 1'b0, 4'd5},  // R5 even half invalid
        '{32'h0080_6345, 1'b1, 8'h99, 2'd0, 32'h3100_2345, 1'b1, 4'd3},  // R3 16 KiB odd half
        '{32'h0080_8000, 1'b0, 8'h99, 2'd1, 32'h0000_0000, 1'b0, 4'd9},  // R9 beyond large page
        '{32'hC000_0FFF, 1'b0, 8'h00, 2'd0, 32'h0600_0FFF, 1'b1, 4'd6},  // R6 last index
        '{32'hC000_1000, 1'b0, 8'h00, 2'd2, 32'h0000_0000, 1'b0, 4'd5},  // R5 odd invalid
        '{32'h0040_0000, 1'b0, 8'h44, 2'd0, 32'h5000_0000, 1'b1, 4'd8}   // R8 only global remains
    };

    task automatic check(input string tag, input logic ok, input logic [31:0] act_pa,
                         input logic [1:0] act_code, input logic [31:0] exp_pa,
                         input logic [1:0] exp_code);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual code=%0d pa=%h expected code=%0d pa=%h",
                     tag, act_code, act_pa, exp_code, exp_pa);
        end
    endtask

    task automatic load(input int idx, input logic g, input logic [7:0] asid,
                        input logic [31:0] vpn, input logic [31:0] pmask,
                        input logic [31:0] p0, input logic v0, input logic d0,
                        input logic [31:0] p1, input logic v1, input logic d1);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 4'(idx); wr_global = g; wr_asid = asid;
        wr_vpn = vpn; wr_pmask = pmask;
        wr_pfn0 = p0; wr_v0 = v0; wr_d0 = d0;
        wr_pfn1 = p1; wr_v1 = v1; wr_d1 = d1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic lookup(input logic [31:0] va, input logic w, input logic [7:0] asid);
        @(negedge clk);
        req_valid = 1'b1; req_va = va; req_write = w; req_asid = asid;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL R11 watchdog actual=hung expected=finished");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 idle after reset", !rsp_valid && req_ready, rsp_pa, rsp_code, 32'h0, 2'd1);
        lookup(32'h0000_0000, 1'b0, 8'h00);
        check("R1 empty lookup", rsp_valid && rsp_code == 2'd1 && rsp_pa == 0,
              rsp_pa, rsp_code, 32'h0, 2'd1);

        load(0,  1'b0, 8'h11, 32'h0040_0000, 32'h0, 32'h1000_0000, 1, 1, 32'h2000_0000, 1, 0);
        load(1,  1'b1, 8'h55, 32'h0080_0000, 32'h0000_6000, 32'h3000_0000, 0, 0, 32'h3100_0000, 1, 1);
        load(2,  1'b0, 8'h22, 32'h0040_0000, 32'h0, 32'h4000_0000, 1, 1, 32'h4100_0000, 1, 1);
        load(3,  1'b1, 8'h00, 32'h0040_0000, 32'h0, 32'h5000_0000, 1, 1, 32'h5100_0000, 1, 1);
        load(15, 1'b1, 8'h00, 32'hC000_0000, 32'h0, 32'h0600_0000, 1, 1, 32'h0, 0, 0);

        for (int i = 0; i < 12; i++) begin
            lookup(VEC[i].va, VEC[i].wr, VEC[i].asid);
            check($sformatf("R%0d vector %0d", VEC[i].req, i),
                  rsp_valid && rsp_code == VEC[i].code && rsp_pa == VEC[i].pa &&
                  rsp_rd == (VEC[i].code == 2'd0) && rsp_wr == VEC[i].wperm,
                  rsp_pa, rsp_code, VEC[i].pa, VEC[i].code);
        end

        // R10: write and lookup in the same cycle sees the old contents
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 4'd4; wr_global = 1'b1; wr_asid = 8'h00;
        wr_vpn = 32'h7000_0000; wr_pmask = 32'h0;
        wr_pfn0 = 32'h0900_0000; wr_v0 = 1'b1; wr_d0 = 1'b1;
        wr_pfn1 = 32'h0; wr_v1 = 1'b0; wr_d1 = 1'b0;
        req_valid = 1'b1; req_va = 32'h7000_0042; req_write = 1'b0; req_asid = 8'h07;
        @(negedge clk);
        wr_en = 1'b0; req_valid = 1'b0;
        check("R10 same-cycle lookup", rsp_valid && rsp_code == 2'd1, rsp_pa, rsp_code, 32'h0, 2'd1);
        lookup(32'h7000_0042, 1'b0, 8'h07);
        check("R10 next-cycle lookup", rsp_valid && rsp_code == 2'd0 && rsp_pa == 32'h0900_0042,
              rsp_pa, rsp_code, 32'h0900_0042, 2'd0);

        // R9: an entry with both halves invalid is silent
        load(4, 1'b1, 8'h00, 32'h7000_0000, 32'h0, 32'h0900_0000, 0, 1, 32'h0, 0, 1);
        lookup(32'h7000_0042, 1'b0, 8'h07);
        check("R9 dead entry", rsp_valid && rsp_code == 2'd1, rsp_pa, rsp_code, 32'h0, 2'd1);

        // R11: back-pressure holds the response
        @(negedge clk);
        rsp_ready = 1'b0;
        req_valid = 1'b1; req_va = 32'h0040_0123; req_write = 1'b0; req_asid = 8'h11;
        @(negedge clk);
        req_va = 32'hC000_0004; req_asid = 8'h00;
        check("R11 stall ready low", rsp_valid && !req_ready && rsp_pa == 32'h1000_0123,
              rsp_pa, rsp_code, 32'h1000_0123, 2'd0);
        @(negedge clk);
        check("R11 held response", rsp_valid && rsp_code == 2'd0 && rsp_pa == 32'h1000_0123,
              rsp_pa, rsp_code, 32'h1000_0123, 2'd0);
        rsp_ready = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        check("R11 queued request answered", rsp_valid && rsp_code == 2'd0 && rsp_pa == 32'h0600_0004,
              rsp_pa, rsp_code, 32'h0600_0004, 2'd0);
        @(negedge clk);
        check("R11 drained", !rsp_valid && req_ready, rsp_pa, rsp_code, 32'h0, 2'd0);

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule